// File: doc/BRIEF.md
# ADC Auto-Zero and Gain Calibration Sequencer

This block steps an eight-input multiplexed analog-to-digital converter through a fixed reading cycle and turns each raw signal reading into a calibrated value. Channel 0 of the multiplexer is wired to ground and channel 1 to a stable reference voltage. Channels 2 to 7 carry three current inputs, and each input is read at two gain ranges. Every cycle, the block first converts ground and reference. It then converts the six signal channels in order and corrects each one. The ground reading removes offset and the reference reading removes gain drift.

The correction is `(raw - zero) * FULL / (ref - zero)`, where FULL is the all-ones code of the converter width. A multi-cycle restoring divider computes it, and the result is clamped to the range 0..FULL. If the reference reading of a cycle is not above the ground reading, the gain cannot be trusted. Every corrected output of that cycle is then flagged bad instead of divided. Calibration values are measured again in every cycle, so drift is followed from one cycle to the next. A strobe marks the end of each cycle.

Top module: `acal_seq`

## Requirements
- R1: While reset is held, res_valid and cycle_done are 0; after reset releases, the first conversion request selects channel 0.
- R2: Each cycle requests channels 0,1,2,...,7 in that order, one request per channel. conv_req stays high with conv_sel stable until conv_done is seen, then drops for at least one cycle.
- R3: The channel 0 reading becomes the zero value and the channel 1 reading becomes the reference value. Both are latched before any correction starts, and the values from the same cycle are used for that cycle's six signal readings.
- R4: With ref > zero and zero < raw, res_value equals floor((raw - zero) * FULL / (ref - zero)), with FULL = 2^W - 1 (255 for W = 8).
- R5: res_value is 0 when raw <= zero and is clamped to FULL when the quotient exceeds FULL.
- R6: When ref <= zero, each of the six outputs of that cycle still appears with res_bad = 1 and res_value = 0. Otherwise res_bad = 0.
- R7: Each output carries res_chan equal to the multiplexer channel it came from (2..7). res_range equals bit 0 of that channel: 0 for the low range on even channels, 1 for the high range on odd channels.
- R8: cycle_done is a one-cycle pulse in the cycle after the channel 7 output pulse, and it never coincides with res_valid.
- R9: res_valid is a one-cycle pulse given exactly six times per cycle, once per signal channel, in channel order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_req | output | 1 | Conversion request, held until conv_done |
| conv_sel | output | 3 | Multiplexer channel for the current request |
| conv_done | input | 1 | Conversion finished, conv_data valid |
| conv_data | input | W | Raw conversion result |
| res_valid | output | 1 | One-cycle pulse: corrected result available |
| res_value | output | W | Corrected, clamped result |
| res_chan | output | 3 | Source multiplexer channel of the result |
| res_range | output | 1 | Gain range of the result |
| res_bad | output | 1 | Calibration of this cycle invalid |
| cycle_done | output | 1 | One-cycle pulse after the last channel of a cycle |

## Verification
The converter model runs six reading cycles, each with its own ground and reference levels. A wide span (0/255) makes the correction close to identity, and an offset span (10/200) exercises ordinary scaling. A narrow span (50/100) puts readings below ground and above reference, which separates plain scaling from the clamps at both ends. Cycles with reference equal to ground and with reference below ground show that the bad flag replaces division. A final cycle with a span of one and fresh calibration values shows that earlier cycles' zero and reference values are not reused, and it drives the largest quotient into the clamp.

// File: rtl/acal_pkg.sv
package acal_pkg;
    localparam int CH_W      = 3;
    localparam int CH_GND    = 0;
    localparam int CH_REF    = 1;
    localparam int CH_FIRST  = 2;
    localparam int CH_LAST   = 7;

    typedef enum logic [1:0] {
        ST_REQ  = 2'd0,
        ST_NEXT = 2'd1,
        ST_CALC = 2'd2,
        ST_DIV  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/acal_prep.sv
module acal_prep #(
    parameter int W = 8
) (
    input  logic [W-1:0]   zero_i,
    input  logic [W-1:0]   refr_i,
    input  logic [W-1:0]   raw_i,
    output logic [2*W-1:0] num_o,
    output logic [W-1:0]   den_o,
    output logic           cal_ok_o
);
    localparam logic [2*W-1:0] FULL_X = {{W{1'b0}}, {W{1'b1}}};

    logic [2*W-1:0] diff_x;

    always_comb begin
        cal_ok_o = (refr_i > zero_i);
        den_o    = refr_i - zero_i;
        diff_x   = {{W{1'b0}}, raw_i - zero_i};
        if (raw_i > zero_i) begin
            num_o = diff_x * FULL_X;
        end else begin
            num_o = '0;
        end
    end
endmodule

// File: rtl/acal_div.sv
module acal_div #(
    parameter int NW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic          done_o,
    output logic [NW-1:0] quo_o
);
    localparam int CW = $clog2(NW + 1);

    typedef struct packed {
        logic [DW-1:0] rem;
        logic [NW-1:0] quo;
        logic [CW-1:0] cnt;
        logic          run;
        logic          done;
    } div_t;

    div_t q, d;
    logic [DW:0] shifted;
    logic [DW:0] trial;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem, q.quo[NW-1]};
        trial   = shifted - {1'b0, den_i};
        if (start_i) begin
            d.rem = '0;
            d.quo = num_i;
            d.cnt = CW'(NW);
            d.run = 1'b1;
        end else if (q.run) begin
            if (!trial[DW]) begin
                d.rem = trial[DW-1:0];
                d.quo = {q.quo[NW-2:0], 1'b1};
            end else begin
                d.rem = shifted[DW-1:0];
                d.quo = {q.quo[NW-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign quo_o  = q.quo;
endmodule

// File: rtl/acal_seq.sv
module acal_seq
    import acal_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            conv_req,
    output logic [CH_W-1:0] conv_sel,
    input  logic            conv_done,
    input  logic [W-1:0]    conv_data,
    output logic            res_valid,
    output logic [W-1:0]    res_value,
    output logic [CH_W-1:0] res_chan,
    output logic            res_range,
    output logic            res_bad,
    output logic            cycle_done
);
    localparam int NW = 2 * W;
    localparam logic [NW-1:0] FULL_N = {{W{1'b0}}, {W{1'b1}}};

    typedef struct packed {
        seq_state_e      st;
        logic [CH_W-1:0] ch;
        logic [W-1:0]    zero;
        logic [W-1:0]    refr;
        logic [W-1:0]    raw;
        logic            ovalid;
        logic [W-1:0]    ovalue;
        logic [CH_W-1:0] ochan;
        logic            orange;
        logic            obad;
        logic            cdone;
    } seq_t;

    seq_t q, d;

    logic [NW-1:0] num;
    logic [W-1:0]  den;
    logic          cal_ok;
    logic          div_start;
    logic          div_done;
    logic [NW-1:0] quo;

    acal_prep #(.W(W)) u_prep (
        .zero_i   (q.zero),
        .refr_i   (q.refr),
        .raw_i    (q.raw),
        .num_o    (num),
        .den_o    (den),
        .cal_ok_o (cal_ok)
    );

    assign div_start = (q.st == ST_CALC) && cal_ok;

    acal_div #(.NW(NW), .DW(W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (num),
        .den_i   (den),
        .done_o  (div_done),
        .quo_o   (quo)
    );

    always_comb begin
        d        = q;
        d.ovalid = 1'b0;
        d.cdone  = 1'b0;
        case (q.st)
            ST_REQ: begin
                if (conv_done) begin
                    if (q.ch == CH_W'(CH_GND)) begin
                        d.zero = conv_data;
                        d.st   = ST_NEXT;
                    end else if (q.ch == CH_W'(CH_REF)) begin
                        d.refr = conv_data;
                        d.st   = ST_NEXT;
                    end else begin
                        d.raw = conv_data;
                        d.st  = ST_CALC;
                    end
                end
            end
            ST_CALC: begin
                if (cal_ok) begin
                    d.st = ST_DIV;
                end else begin
                    d.ovalid = 1'b1;
                    d.obad   = 1'b1;
                    d.ovalue = '0;
                    d.ochan  = q.ch;
                    d.orange = q.ch[0];
                    d.st     = ST_NEXT;
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    d.ovalid = 1'b1;
                    d.obad   = 1'b0;
                    d.ovalue = (quo > FULL_N) ? {W{1'b1}} : quo[W-1:0];
                    d.ochan  = q.ch;
                    d.orange = q.ch[0];
                    d.st     = ST_NEXT;
                end
            end
            default: begin
                if (q.ch == CH_W'(CH_LAST)) begin
                    d.ch    = CH_W'(CH_GND);
                    d.cdone = 1'b1;
                end else begin
                    d.ch = q.ch + 1'b1;
                end
                d.st = ST_REQ;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign conv_req   = (q.st == ST_REQ);
    assign conv_sel   = q.ch;
    assign res_valid  = q.ovalid;
    assign res_value  = q.ovalue;
    assign res_chan   = q.ochan;
    assign res_range  = q.orange;
    assign res_bad    = q.obad;
    assign cycle_done = q.cdone;
endmodule

// File: rtl/acal_seq_chk.sv
module acal_seq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_req,
    input logic [2:0]   conv_sel,
    input logic         conv_done,
    input logic [W-1:0] conv_data,
    input logic         res_valid,
    input logic [W-1:0] res_value,
    input logic [2:0]   res_chan,
    input logic         res_range,
    input logic         res_bad,
    input logic         cycle_done
);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done) |=> (conv_req && $stable(conv_sel)));

    assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_done) |=> !conv_req);

    assert_bad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_bad) |-> (res_value == '0));

    assert_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_chan >= 3'd2) && (res_range == res_chan[0])));

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, cycle_done}));

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> ($past(res_valid) && ($past(res_chan) == 3'd7)));

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (conv_req && (conv_sel == 3'd0)));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

bind acal_seq acal_seq_chk #(.W(W)) u_chk (.*);

// File: tb/tb_acal_seq.sv
module tb_acal_seq;
    localparam int W = 8;
    localparam int NCYC = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_req;
    logic [2:0]   conv_sel;
    logic         conv_done = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         res_valid;
    logic [W-1:0] res_value;
    logic [2:0]   res_chan;
    logic         res_range;
    logic         res_bad;
    logic         cycle_done;

    acal_seq #(.W(W)) dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        int value;
        int chan;
        int bad;
        int tag;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_err = 0;
    int nreq = 0;
    int ndone = 0;
    int outs_since = 0;
    int last_chan = -1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic string tname(input int t);
        case (t)
            3: return "R3";
            5: return "R5";
            6: return "R6";
            default: return "R4";
        endcase
    endfunction

    function automatic int adc_val(input int c, input int ch);
        int v[8];
        case (c)
            0: v = '{10, 200, 10, 105, 200, 11, 57, 150};
            1: v = '{0, 255, 0, 1, 128, 254, 255, 77};
            2: v = '{50, 100, 0, 49, 50, 51, 100, 250};
            3: v = '{80, 80, 90, 10, 200, 80, 81, 5};
            4: v = '{120, 30, 0, 255, 121, 60, 30, 119};
            default: v = '{3, 4, 3, 4, 5, 2, 255, 0};
        endcase
        return v[ch];
    endfunction

    task automatic push_exp(input int c, input int ch, input int x);
        exp_t e;
        int g, r, qv;
        g = adc_val(c, 0);
        r = adc_val(c, 1);
        e.chan = ch;
        if (r <= g) begin
            e.bad = 1; e.value = 0; e.tag = 6;
        end else begin
            e.bad = 0;
            if (x <= g) begin
                e.value = 0; e.tag = 5;
            end else begin
                qv = (x - g) * 255 / (r - g);
                if (qv > 255) begin
                    e.value = 255; e.tag = 5;
                end else begin
                    e.value = qv; e.tag = 4;
                end
            end
            if (c == NCYC - 1) e.tag = 3;
        end
        sb.push_back(e);
    endtask

    // converter model and driver
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (conv_req && nreq < NCYC * 8) begin
                int c, ch;
                c = nreq / 8;
                ch = nreq % 8;
                chk(conv_sel == 3'(ch), "R2", int'(conv_sel), ch);
                repeat (nreq % 3) @(negedge clk);
                chk(conv_req && conv_sel == 3'(ch), "R2", int'(conv_sel), ch);
                if (ch >= 2) push_exp(c, ch, adc_val(c, ch));
                conv_data = W'(adc_val(c, ch));
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
                chk(!conv_req, "R2", int'(conv_req), 0);
                nreq++;
            end
        end
    end

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (res_valid) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R9", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        chk(int'(res_value) == e.value, tname(e.tag), int'(res_value), e.value);
                        chk(int'(res_bad) == e.bad, "R6", int'(res_bad), e.bad);
                        chk(int'(res_chan) == e.chan, "R7", int'(res_chan), e.chan);
                        chk(int'(res_range) == (e.chan % 2), "R7", int'(res_range), e.chan % 2);
                    end
                    outs_since++;
                    last_chan = int'(res_chan);
                end
                if (cycle_done) begin
                    chk(last_chan == 7, "R8", last_chan, 7);
                    chk(outs_since == 6, "R9", outs_since, 6);
                    chk(!res_valid, "R8", int'(res_valid), 0);
                    ndone++;
                    outs_since = 0;
                end
            end
        end
    end

    initial begin
        int wd;
        repeat (3) @(negedge clk);
        chk(!res_valid && !cycle_done, "R1", int'(res_valid) + int'(cycle_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(conv_req && conv_sel == 3'd0, "R1", int'(conv_sel), 0);
        wd = 0;
        while (ndone < NCYC && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        chk(wd < 20000, "R9", ndone, NCYC);
        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R9", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule